// File: doc/BRIEF.md
# Extended-Precision Compare and Classify Unit

This block examines operands held in the 80-bit extended floating-point format: one sign bit (bit 79), a 15-bit biased exponent (bits 78..64) and a 64-bit significand (bits 63..0). The leading integer bit of the significand is bit 63. It is stored explicitly, not implied. The block reports its result through four condition bits, C3, C2, C1 and C0, and an invalid flag. It serves three operations. Compare orders the top-of-stack operand against a source operand. Test orders the top-of-stack operand against zero. Examine places the top-of-stack operand, together with its empty tag, into one of seven classes.

Ordering is by numeric value, not by raw bit pattern. Unnormal and denormal encodings are normalised before their magnitudes are compared, so two encodings of the same value compare equal. NaNs and an empty top-of-stack register give the unordered code. A parameter chooses whether the result appears combinationally or one clock later from an output register.

Top module: `fxc_cmp_unit`

## Requirements
- R1: With op_sel=2'b00 (compare) and ordered operands, cc={C3,C2,C1,C0} is 4'b0000 when st_val is numerically greater than src_val, 4'b0001 when it is less, and 4'b1000 when it is equal. Unnormal and denormal encodings are ordered by their true value (a zero exponent field is weighted like exponent 1), and invalid is 0.
- R2: Positive zero and negative zero compare equal (4'b1000), and so does any significand-zero encoding.
- R3: In compare or test, a NaN in any examined operand (an all-ones exponent, except significand 64'h8000_0000_0000_0000) or st_empty=1 gives cc=4'b1101 with invalid=1.
- R4: In compare and test mode, C1 (cc[1]) is always 0.
- R5: With op_sel=2'b01 (test), st_val is ordered against zero with the R1 codes: positive 0000, negative 0001, zero of either sign 1000. src_val has no effect, even when it holds a NaN.
- R6: With op_sel=2'b10 (examine), {C3,C2,C0} is 000 for unnormal (exponent neither 0 nor all-ones, bit 63 clear), 010 for normal, 100 for zero, 110 for denormal (exponent 0, significand nonzero), 001 for NaN and 011 for infinity (all-ones exponent, bit 63 set, bits 62..0 clear).
- R7: In examine mode C1 equals st_val[79]. With st_empty=1 the code is C3=1, C2=0, C0=1, whatever the value.
- R8: Examine never raises invalid, even for a NaN operand.
- R9: op_sel=2'b11 is reserved and gives cc=4'b0000 with invalid=0.
- R10: With OUT_REG=1, outputs follow their inputs by one clock and are 0 while rst is high. With OUT_REG=0, outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | 00 compare, 01 test, 10 examine, 11 reserved |
| st_val | input | 80 | Top-of-stack operand |
| src_val | input | 80 | Source operand for compare |
| st_empty | input | 1 | Tag marking the top-of-stack register empty |
| cc | output | 4 | Condition bits {C3,C2,C1,C0} |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds two copies of the block at the default 15-bit exponent and 64-bit significand, one with OUT_REG=1 and one with OUT_REG=0, and drives both from the same inputs. The registered copy exposes the one-cycle latency and the reset clearing of the outputs. The combinational copy checks each result in the cycle it is applied. Keeping the full 64-bit significand brings the normaliser's longest shifts within reach: a denormal holding only bit 0, and an unnormal that must compare equal to a normal of the same value.

// File: rtl/fxc_pkg.sv
`timescale 1ns/1ps
package fxc_pkg;

    typedef enum logic [1:0] {
        OP_CMP = 2'b00,
        OP_TST = 2'b01,
        OP_EXM = 2'b10,
        OP_RSV = 2'b11
    } fxc_op_e;

    typedef enum logic [2:0] {
        CL_UNN,
        CL_NRM,
        CL_ZER,
        CL_DEN,
        CL_NAN,
        CL_INF,
        CL_EMP
    } fxc_cls_e;

    typedef enum logic [1:0] {
        ORD_GT,
        ORD_LT,
        ORD_EQ
    } fxc_ord_e;

    typedef struct packed {
        logic [3:0] cc;
        logic       inv;
    } fxc_res_t;

    localparam logic [3:0] CC_GT = 4'b0000;
    localparam logic [3:0] CC_LT = 4'b0001;
    localparam logic [3:0] CC_EQ = 4'b1000;
    localparam logic [3:0] CC_UN = 4'b1101;

    // Examine code: {C3,C2,C1,C0} with C1 carrying the sign
    function automatic logic [3:0] exam_code(input fxc_cls_e cls, input logic sgn);
        logic [2:0] k;
        case (cls)
            CL_UNN:  k = 3'b000;
            CL_NRM:  k = 3'b010;
            CL_ZER:  k = 3'b100;
            CL_DEN:  k = 3'b110;
            CL_NAN:  k = 3'b001;
            CL_INF:  k = 3'b011;
            default: k = 3'b101;
        endcase
        return {k[2], k[1], sgn, k[0]};
    endfunction

    function automatic logic [3:0] ord_code(input fxc_ord_e o);
        case (o)
            ORD_GT:  return CC_GT;
            ORD_LT:  return CC_LT;
            default: return CC_EQ;
        endcase
    endfunction

endpackage

// File: rtl/fxc_norm.sv
`timescale 1ns/1ps
module fxc_norm #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int LZ_W = $clog2(SIG_W) + 1,
    localparam int EE_W = EXP_W + 2
) (
    input  logic [EXP_W-1:0]       exp_in,
    input  logic [SIG_W-1:0]       sig_in,
    output logic signed [EE_W-1:0] eff_exp,
    output logic [SIG_W-1:0]       sig_norm,
    output logic                   is_zero
);
    logic [LZ_W-1:0]  lz;
    logic             found;
    logic [EXP_W-1:0] base;

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (sig_in[i]) found = 1'b1;
                else           lz    = lz + LZ_W'(1);
            end
        end
    end

    // A zero exponent field carries the weight of exponent 1
    assign base     = (exp_in == '0) ? EXP_W'(1) : exp_in;
    assign eff_exp  = $signed({2'b00, base}) - $signed({{(EE_W-LZ_W){1'b0}}, lz});
    assign sig_norm = sig_in << lz;
    assign is_zero  = (sig_in == '0);

endmodule

// File: rtl/fxc_classify.sv
`timescale 1ns/1ps
module fxc_classify
    import fxc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int TOT_W = 1 + EXP_W + SIG_W
) (
    input  logic [TOT_W-1:0] val,
    input  logic             empty,
    output fxc_cls_e         cls,
    output logic             sgn
);
    logic [EXP_W-1:0] ex;
    logic [SIG_W-1:0] sg;
    logic             int_bit;
    logic             frac_zero;

    assign sgn       = val[TOT_W-1];
    assign ex        = val[TOT_W-2 -: EXP_W];
    assign sg        = val[SIG_W-1:0];
    assign int_bit   = sg[SIG_W-1];
    assign frac_zero = (sg[SIG_W-2:0] == '0);

    always_comb begin
        if (empty)
            cls = CL_EMP;
        else if (ex == '1)
            cls = (int_bit && frac_zero) ? CL_INF : CL_NAN;
        else if (ex == '0)
            cls = (sg == '0) ? CL_ZER : CL_DEN;
        else
            cls = int_bit ? CL_NRM : CL_UNN;
    end

endmodule

// File: rtl/fxc_order.sv
`timescale 1ns/1ps
module fxc_order
    import fxc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int EE_W = EXP_W + 2
) (
    input  logic             a_sgn,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sgn,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    output fxc_ord_e         ord
);
    logic [1:0][EXP_W-1:0]       exps;
    logic [1:0][SIG_W-1:0]       sigs;
    logic signed [EE_W-1:0]      eff [2];
    logic [SIG_W-1:0]            nsig [2];
    logic [1:0]                  zer;
    logic                        mag_gt;
    logic                        mag_eq;

    assign exps = {b_exp, a_exp};
    assign sigs = {b_sig, a_sig};

    for (genvar k = 0; k < 2; k++) begin : g_norm
        fxc_norm #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_norm (
            .exp_in  (exps[k]),
            .sig_in  (sigs[k]),
            .eff_exp (eff[k]),
            .sig_norm(nsig[k]),
            .is_zero (zer[k])
        );
    end

    assign mag_gt = (eff[0] > eff[1]) || ((eff[0] == eff[1]) && (nsig[0] > nsig[1]));
    assign mag_eq = (eff[0] == eff[1]) && (nsig[0] == nsig[1]);

    always_comb begin
        if (zer[0] && zer[1])
            ord = ORD_EQ;
        else if (zer[0])
            ord = b_sgn ? ORD_GT : ORD_LT;
        else if (zer[1])
            ord = a_sgn ? ORD_LT : ORD_GT;
        else if (a_sgn != b_sgn)
            ord = a_sgn ? ORD_LT : ORD_GT;
        else if (mag_eq)
            ord = ORD_EQ;
        else if (mag_gt ^ a_sgn)
            ord = ORD_GT;
        else
            ord = ORD_LT;
    end

endmodule

// File: rtl/fxc_cmp_unit.sv
`timescale 1ns/1ps
module fxc_cmp_unit
    import fxc_pkg::*;
#(
    parameter int EXP_W   = 15,
    parameter int SIG_W   = 64,
    parameter bit OUT_REG = 1'b1,
    localparam int TOT_W  = 1 + EXP_W + SIG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_sel,
    input  logic [TOT_W-1:0] st_val,
    input  logic [TOT_W-1:0] src_val,
    input  logic             st_empty,
    output logic [3:0]       cc,
    output logic             invalid
);
    fxc_op_e          op;
    fxc_cls_e         st_cls, src_cls;
    logic             st_sgn, src_sgn;
    logic             b_sgn;
    logic [EXP_W-1:0] b_exp;
    logic [SIG_W-1:0] b_sig;
    fxc_ord_e         ord;
    fxc_res_t         nxt;
    logic             unord;

    assign op = fxc_op_e'(op_sel);

    fxc_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_st (
        .val(st_val), .empty(st_empty), .cls(st_cls), .sgn(st_sgn)
    );

    fxc_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_src (
        .val(src_val), .empty(1'b0), .cls(src_cls), .sgn(src_sgn)
    );

    // Test mode orders against +0
    assign b_sgn = (op == OP_TST) ? 1'b0 : src_sgn;
    assign b_exp = (op == OP_TST) ? '0 : src_val[TOT_W-2 -: EXP_W];
    assign b_sig = (op == OP_TST) ? '0 : src_val[SIG_W-1:0];

    fxc_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
        .a_sgn(st_sgn),
        .a_exp(st_val[TOT_W-2 -: EXP_W]),
        .a_sig(st_val[SIG_W-1:0]),
        .b_sgn(b_sgn),
        .b_exp(b_exp),
        .b_sig(b_sig),
        .ord  (ord)
    );

    assign unord = st_empty || (st_cls == CL_NAN) ||
                   ((op == OP_CMP) && (src_cls == CL_NAN));

    always_comb begin
        nxt = '0;
        case (op)
            OP_CMP, OP_TST: begin
                if (unord) begin
                    nxt.cc  = CC_UN;
                    nxt.inv = 1'b1;
                end else begin
                    nxt.cc  = ord_code(ord);
                end
            end
            OP_EXM:  nxt.cc = exam_code(st_cls, st_sgn);
            default: nxt    = '0;
        endcase
    end

    if (OUT_REG) begin : g_reg
        fxc_res_t res_q;
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= nxt;
        end
        assign cc      = res_q.cc;
        assign invalid = res_q.inv;
    end else begin : g_comb
        assign cc      = nxt.cc;
        assign invalid = nxt.inv;
    end

endmodule

// File: rtl/fxc_cmp_unit_chk.sv
`timescale 1ns/1ps
module fxc_cmp_unit_chk #(
    parameter int TOT_W = 80,
    parameter bit LAT   = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       op_sel,
    input logic [TOT_W-1:0] st_val,
    input logic             st_empty,
    input logic [3:0]       cc,
    input logic             invalid
);
    logic [1:0] op_q;
    logic       sgn_q;
    logic       emp_q;

    if (LAT) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst) begin
                op_q  <= 2'b00;
                sgn_q <= 1'b0;
                emp_q <= 1'b0;
            end else begin
                op_q  <= op_sel;
                sgn_q <= st_val[TOT_W-1];
                emp_q <= st_empty;
            end
        end
    end else begin : g_now
        assign op_q  = op_sel;
        assign sgn_q = st_val[TOT_W-1];
        assign emp_q = st_empty;
    end

    // R4
    cmp_c1_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_q != 2'b10 && op_q != 2'b11) |-> !cc[1]);

    // R3
    unord_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_q == 2'b00 || op_q == 2'b01) && cc[2]) |-> (cc[3] && cc[0] && invalid));

    // R8
    exam_no_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (op_q == 2'b10) |-> !invalid);

    // R7
    exam_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (op_q == 2'b10) |-> (cc[1] == sgn_q));

    // R7
    exam_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (op_q == 2'b10 && emp_q) |-> (cc[3] && !cc[2] && cc[0]));

    // R9
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op_q == 2'b11) |-> (cc == 4'b0000 && !invalid));

endmodule

bind fxc_cmp_unit fxc_cmp_unit_chk #(.TOT_W(TOT_W), .LAT(OUT_REG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_sel  (op_sel),
    .st_val  (st_val),
    .st_empty(st_empty),
    .cc      (cc),
    .invalid (invalid)
);

// File: tb/fxc_cmp_unit_tb.sv
`timescale 1ns/1ps
module fxc_cmp_unit_tb;

    localparam logic [79:0] ONE  = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] NONE = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] TWO  = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] NTWO = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] HALF = {1'b0, 15'h3FFE, 64'h8000_0000_0000_0000};
    localparam logic [79:0] UNN  = {1'b0, 15'h3FFF, 64'h4000_0000_0000_0000};
    localparam logic [79:0] PZ   = 80'h0;
    localparam logic [79:0] NZ   = {1'b1, 79'h0};
    localparam logic [79:0] PINF = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] NINF = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] QNAN = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};
    localparam logic [79:0] PNAN = {1'b0, 15'h7FFF, 64'h0000_0000_0000_0000};
    localparam logic [79:0] DEN  = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};

    typedef struct packed {
        logic [1:0]  op;
        logic [79:0] st;
        logic [79:0] src;
        logic        emp;
        logic [3:0]  cc;
        logic        inv;
    } vec_t;

    localparam int NV = 26;

    localparam vec_t VEC [NV] = '{
        '{2'b00, TWO,  ONE,  1'b0, 4'b0000, 1'b0},
        '{2'b00, ONE,  TWO,  1'b0, 4'b0001, 1'b0},
        '{2'b00, ONE,  ONE,  1'b0, 4'b1000, 1'b0},
        '{2'b00, PZ,   NZ,   1'b0, 4'b1000, 1'b0},
        '{2'b00, NONE, ONE,  1'b0, 4'b0001, 1'b0},
        '{2'b00, NONE, NTWO, 1'b0, 4'b0000, 1'b0},
        '{2'b00, QNAN, ONE,  1'b0, 4'b1101, 1'b1},
        '{2'b00, ONE,  PINF, 1'b0, 4'b0001, 1'b0},
        '{2'b00, UNN,  HALF, 1'b0, 4'b1000, 1'b0},
        '{2'b00, DEN,  PZ,   1'b0, 4'b0000, 1'b0},
        '{2'b01, NONE, PZ,   1'b0, 4'b0001, 1'b0},
        '{2'b01, NZ,   ONE,  1'b0, 4'b1000, 1'b0},
        '{2'b01, DEN,  PZ,   1'b0, 4'b0000, 1'b0},
        '{2'b01, QNAN, PZ,   1'b0, 4'b1101, 1'b1},
        '{2'b10, ONE,  PZ,   1'b0, 4'b0100, 1'b0},
        '{2'b10, NONE, PZ,   1'b0, 4'b0110, 1'b0},
        '{2'b10, UNN,  PZ,   1'b0, 4'b0000, 1'b0},
        '{2'b10, NZ,   PZ,   1'b0, 4'b1010, 1'b0},
        '{2'b10, DEN,  PZ,   1'b0, 4'b1100, 1'b0},
        '{2'b10, QNAN, PZ,   1'b0, 4'b0001, 1'b0},
        '{2'b10, NINF, PZ,   1'b0, 4'b0111, 1'b0},
        '{2'b10, PNAN, PZ,   1'b0, 4'b0001, 1'b0},
        '{2'b10, NONE, PZ,   1'b1, 4'b1011, 1'b0},
        '{2'b00, ONE,  ONE,  1'b1, 4'b1101, 1'b1},
        '{2'b11, QNAN, ONE,  1'b0, 4'b0000, 1'b0},
        '{2'b01, ONE,  QNAN, 1'b0, 4'b0000, 1'b0}
    };

    localparam string TAG [NV] = '{
        "R1", "R1", "R1", "R2", "R1", "R1", "R3", "R1", "R1", "R1",
        "R5", "R5", "R5", "R3", "R6", "R7", "R6", "R6", "R6", "R8",
        "R6", "R6", "R7", "R3", "R9", "R5"
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op_sel;
    logic [79:0] st_val, src_val;
    logic        st_empty;
    logic [3:0]  cc_r, cc_c;
    logic        inv_r, inv_c;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fxc_cmp_unit #(.OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .st_val(st_val), .src_val(src_val),
        .st_empty(st_empty), .cc(cc_r), .invalid(inv_r)
    );

    fxc_cmp_unit #(.OUT_REG(1'b0)) u_dut_c (
        .clk(clk), .rst(rst), .op_sel(op_sel), .st_val(st_val), .src_val(src_val),
        .st_empty(st_empty), .cc(cc_c), .invalid(inv_c)
    );

    task automatic check(input string tag, input string who,
                         input logic [3:0] got_cc, input logic got_inv,
                         input logic [3:0] exp_cc, input logic exp_inv);
        n_run++;
        if (got_cc !== exp_cc || got_inv !== exp_inv) begin
            n_fail++;
            $display("FAIL %s %s: cc=%b inv=%b expected cc=%b inv=%b",
                     tag, who, got_cc, got_inv, exp_cc, exp_inv);
        end
    endtask

    task automatic apply(input vec_t v);
        op_sel   = v.op;
        st_val   = v.st;
        src_val  = v.src;
        st_empty = v.emp;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        op_sel   = 2'b00;
        st_val   = QNAN;
        src_val  = ONE;
        st_empty = 1'b0;
        repeat (3) @(negedge clk);
        // R10: registered copy held at zero in reset; combinational copy live (R3)
        check("R10", "reset", cc_r, inv_r, 4'b0000, 1'b0);
        check("R3", "comb in reset", cc_c, inv_c, 4'b1101, 1'b1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(negedge clk);
            check(TAG[i], "reg", cc_r, inv_r, VEC[i].cc, VEC[i].inv);
            check(TAG[i], "comb", cc_c, inv_c, VEC[i].cc, VEC[i].inv);
        end

        // R10: latency — new inputs visible at once on comb, one clock later on reg
        @(negedge clk);
        apply(VEC[1]);
        #1;
        check("R10", "comb same cycle", cc_c, inv_c, 4'b0001, 1'b0);
        check("R10", "reg previous", cc_r, inv_r, VEC[NV-1].cc, VEC[NV-1].inv);
        @(negedge clk);
        check("R10", "reg after edge", cc_r, inv_r, 4'b0001, 1'b0);

        // R4: compare of infinities of opposite sign keeps C1 clear
        apply('{2'b00, NINF, PINF, 1'b0, 4'b0001, 1'b0});
        @(negedge clk);
        @(negedge clk);
        check("R4", "comb", cc_c, inv_c, 4'b0001, 1'b0);

        // R3: NaN in source only
        apply('{2'b00, ONE, PNAN, 1'b0, 4'b1101, 1'b1});
        @(negedge clk);
        @(negedge clk);
        check("R3", "reg", cc_r, inv_r, 4'b1101, 1'b1);

        // R10: reset mid-run clears registered outputs
        rst = 1'b1;
        @(negedge clk);
        check("R10", "reset mid-run", cc_r, inv_r, 4'b0000, 1'b0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule